// File: doc/BRIEF.md
# Two-Level DMA Request Arbiter

This block chooses which channel a shared transfer engine serves next. Each channel raises a service request, and software can enable or mask it. Channels are grouped into banks of `GRP_SIZE`. At the first level a bank is chosen from among those that have a live request. At the second level a channel is chosen inside that bank. Each level runs its own policy, set by a control input: fixed priority (the highest programmed value wins) or round-robin (the search starts just past the previous winner and wraps).

A grant stays in place while the engine works on it. The engine ends the grant by pulsing `done_i`, and the arbiter decides again on the following clock edge. The arbiter also checks the priority settings for duplicates. Two enabled channels in one bank with the same channel priority is an error. Two banks with the same bank priority is also an error. While either fault is present, no grant is issued.

The default build has 64 channels in 4 banks of 16. A reduced build sets `NUM_CH` to 16, which gives a single bank, so only the channel policy has any effect.

Top module: `dma_req_arb`

## Requirements
- R1: After reset, `gnt_valid_o`, `ch_prio_err_o` and `grp_prio_err_o` are all 0.
- R2: A channel takes part in arbitration only when its bit in `req_i` and its bit in `en_i` are both 1. A request from a disabled channel is never granted.
- R3: With `ch_rr_i` = 0, the winner inside the chosen bank is the active channel with the largest 4-bit priority. The priority of channel c sits at `ch_prio_i[c*4 +: 4]`. Channel c belongs to bank c / 16.
- R4: With `ch_rr_i` = 1, the search inside the chosen bank starts at the channel just after that bank's previous winner and wraps from the last channel back to the first.
- R5: With `grp_rr_i` = 0, the winning bank is the bank with an active channel that has the largest 2-bit bank priority. The priority of bank g sits at `grp_prio_i[g*2 +: 2]`.
- R6: With `grp_rr_i` = 1, the bank search starts at the bank just after the previous winning bank and wraps.
- R7: Once issued, a grant keeps `gnt_valid_o` = 1 with `gnt_ch_o` unchanged until `done_i` is sampled at 1. `gnt_valid_o` then drops on that edge. A new grant can appear no earlier than the edge after that.
- R8: When two enabled channels in the same bank share a channel priority, `ch_prio_err_o` rises one edge later and no grant is issued while the fault lasts.
- R9: When two banks share a bank priority, `grp_prio_err_o` rises one edge later and no grant is issued while the fault lasts.
- R10: With no active channel, no grant is issued.
- R11: After reset, the round-robin pointers make the first search at each level start at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Per-channel service request |
| en_i | input | NUM_CH | Per-channel request enable |
| ch_prio_i | input | NUM_CH*4 | Channel priority table, 4 bits per channel |
| grp_prio_i | input | NUM_GRP*2 | Bank priority table, 2 bits per bank |
| ch_rr_i | input | 1 | 1 selects round-robin inside a bank, 0 selects fixed priority |
| grp_rr_i | input | 1 | 1 selects round-robin across banks, 0 selects fixed priority |
| done_i | input | 1 | Engine finished the granted channel |
| gnt_valid_o | output | 1 | A grant is outstanding |
| gnt_ch_o | output | CH_W | Number of the granted channel |
| ch_prio_err_o | output | 1 | Duplicate channel priority inside a bank |
| grp_prio_err_o | output | 1 | Duplicate bank priority |

## Verification
A grant is registered on the first rising edge after an idle arbiter sees an active request, so the monitor expects it at the falling edge that follows. Both error flags are one register stage behind the priority inputs, so they are checked two half-periods after a change, after one full edge has passed. A release takes effect on the edge where `done_i` is high, and the bench checks for a low `gnt_valid_o` at the next falling edge. The re-grant is then expected one edge later. Every input changes on a falling edge, so each check samples values settled by exactly the number of edges counted above.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned CH_PW  = 4;
  localparam int unsigned GRP_PW = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } arb_st_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  // scan starts one past the previous winner and wraps
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int j;
      j = (int'(last) + k) % int'(N);
      if (!found && vec[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_max_pick.sv
module arb_max_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned KW = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vld,
  input  logic [N*KW-1:0] keys,
  output logic [IW-1:0]   idx
);
  logic          hit;
  logic [KW-1:0] best;

  // largest key wins, ties go to the lower index
  always_comb begin
    hit  = 1'b0;
    best = '0;
    idx  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (vld[i] && (!hit || keys[i*KW +: KW] > best)) begin
        hit  = 1'b1;
        best = keys[i*KW +: KW];
        idx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_dup_check.sv
module arb_dup_check #(
  parameter int unsigned N  = 16,
  parameter int unsigned KW = 4
) (
  input  logic [N-1:0]    vld,
  input  logic [N*KW-1:0] keys,
  output logic            dup
);
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      for (int j = i + 1; j < int'(N); j++) begin
        if (vld[i] && vld[j] && (keys[i*KW +: KW] == keys[j*KW +: KW]))
          dup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH   = 64,
  parameter int unsigned GRP_SIZE = 16,
  localparam int unsigned NUM_GRP = NUM_CH / GRP_SIZE,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned LOC_W   = (GRP_SIZE > 1) ? $clog2(GRP_SIZE) : 1,
  localparam int unsigned GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           req_i,
  input  logic [NUM_CH-1:0]           en_i,
  input  logic [NUM_CH*CH_PW-1:0]     ch_prio_i,
  input  logic [NUM_GRP*GRP_PW-1:0]   grp_prio_i,
  input  logic                        ch_rr_i,
  input  logic                        grp_rr_i,
  input  logic                        done_i,
  output logic                        gnt_valid_o,
  output logic [CH_W-1:0]             gnt_ch_o,
  output logic                        ch_prio_err_o,
  output logic                        grp_prio_err_o
);
  logic [NUM_CH-1:0]  act;
  logic [NUM_GRP-1:0] grp_act;
  logic [NUM_GRP-1:0] ch_dup;
  logic [LOC_W-1:0]   loc_rr  [NUM_GRP];
  logic [LOC_W-1:0]   loc_fx  [NUM_GRP];
  logic [LOC_W-1:0]   last_loc_q [NUM_GRP];
  logic [GRP_W-1:0]   last_grp_q;
  logic [GRP_W-1:0]   g_rr, g_fx, win_grp;
  logic [LOC_W-1:0]   win_loc;
  logic               any_act, grp_dup;
  logic               ch_err_c, grp_err_c;
  logic               fire, rel;
  arb_st_e            st_q, st_d;
  logic [CH_W-1:0]    gnt_ch_q, gnt_ch_d;
  logic               ch_err_q, grp_err_q;

  assign act = req_i & en_i;

  // per-bank candidate selection and duplicate check
  for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_bank
    arb_rr_pick #(.N(GRP_SIZE), .IW(LOC_W)) u_rr (
      .vec   (act[g*GRP_SIZE +: GRP_SIZE]),
      .last  (last_loc_q[g]),
      .found (grp_act[g]),
      .idx   (loc_rr[g])
    );
    arb_max_pick #(.N(GRP_SIZE), .KW(CH_PW), .IW(LOC_W)) u_fx (
      .vld  (act[g*GRP_SIZE +: GRP_SIZE]),
      .keys (ch_prio_i[g*GRP_SIZE*CH_PW +: GRP_SIZE*CH_PW]),
      .idx  (loc_fx[g])
    );
    arb_dup_check #(.N(GRP_SIZE), .KW(CH_PW)) u_dup (
      .vld  (en_i[g*GRP_SIZE +: GRP_SIZE]),
      .keys (ch_prio_i[g*GRP_SIZE*CH_PW +: GRP_SIZE*CH_PW]),
      .dup  (ch_dup[g])
    );
  end

  // bank level
  arb_rr_pick #(.N(NUM_GRP), .IW(GRP_W)) u_grp_rr (
    .vec   (grp_act),
    .last  (last_grp_q),
    .found (any_act),
    .idx   (g_rr)
  );
  arb_max_pick #(.N(NUM_GRP), .KW(GRP_PW), .IW(GRP_W)) u_grp_fx (
    .vld  (grp_act),
    .keys (grp_prio_i),
    .idx  (g_fx)
  );
  arb_dup_check #(.N(NUM_GRP), .KW(GRP_PW)) u_grp_dup (
    .vld  ({NUM_GRP{1'b1}}),
    .keys (grp_prio_i),
    .dup  (grp_dup)
  );

  assign ch_err_c  = |ch_dup;
  assign grp_err_c = grp_dup;
  assign win_grp   = grp_rr_i ? g_rr : g_fx;
  assign win_loc   = ch_rr_i ? loc_rr[win_grp] : loc_fx[win_grp];

  assign fire = (st_q == ST_IDLE) && any_act && !ch_err_c && !grp_err_c;
  assign rel  = (st_q == ST_HOLD) && done_i;

  // next-state
  always_comb begin
    st_d     = st_q;
    gnt_ch_d = gnt_ch_q;
    if (fire) begin
      st_d     = ST_HOLD;
      gnt_ch_d = CH_W'(int'(win_grp) * int'(GRP_SIZE) + int'(win_loc));
    end else if (rel) begin
      st_d = ST_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      gnt_ch_q <= '0;
    end else begin
      st_q <= st_d;
      if (fire) gnt_ch_q <= gnt_ch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_grp_q <= GRP_W'(NUM_GRP - 1);
      for (int g = 0; g < int'(NUM_GRP); g++)
        last_loc_q[g] <= LOC_W'(GRP_SIZE - 1);
    end else if (fire) begin
      last_grp_q          <= win_grp;
      last_loc_q[win_grp] <= win_loc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_err_q  <= 1'b0;
      grp_err_q <= 1'b0;
    end else begin
      ch_err_q  <= ch_err_c;
      grp_err_q <= grp_err_c;
    end
  end

  assign gnt_valid_o    = (st_q == ST_HOLD);
  assign gnt_ch_o       = gnt_ch_q;
  assign ch_prio_err_o  = ch_err_q;
  assign grp_prio_err_o = grp_err_q;
endmodule

// File: rtl/dma_req_arb_chk.sv
module dma_req_arb_chk #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned CH_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] en_i,
  input logic              done_i,
  input logic              gnt_valid_o,
  input logic [CH_W-1:0]   gnt_ch_o,
  input logic              ch_prio_err_o,
  input logic              grp_prio_err_o
);
  a_r2_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid_o) |-> ((($past(req_i & en_i)) >> gnt_ch_o) & NUM_CH'(1)) != '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !done_i) |=> (gnt_valid_o && $stable(gnt_ch_o)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && done_i) |=> !gnt_valid_o);

  a_r7_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_valid_o) |-> $past(done_i));

  a_r8_no_grant_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid_o) |-> (!ch_prio_err_o && !grp_prio_err_o));
endmodule

bind dma_req_arb dma_req_arb_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_i          (req_i),
  .en_i           (en_i),
  .done_i         (done_i),
  .gnt_valid_o    (gnt_valid_o),
  .gnt_ch_o       (gnt_ch_o),
  .ch_prio_err_o  (ch_prio_err_o),
  .grp_prio_err_o (grp_prio_err_o)
);

// File: tb/sim_dma_req_arb.sv
`timescale 1ns/1ps
module sim_dma_req_arb;
  localparam int NCH = 64;
  localparam int NG  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  req, en;
  logic [NCH*4-1:0] chp_v;
  logic [NG*2-1:0]  gp_v;
  logic            ch_rr, grp_rr, done;
  logic            gv;
  logic [5:0]      gch;
  logic            cerr, gerr;

  logic [3:0] chp [NCH];
  logic [1:0] gp  [NG];

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  int exp_q[$];
  string tag_q[$];
  logic prev_v = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) chp_v[c*4 +: 4] = chp[c];
    for (int g = 0; g < NG; g++)  gp_v[g*2 +: 2]  = gp[g];
  end

  dma_req_arb u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en),
    .ch_prio_i(chp_v), .grp_prio_i(gp_v), .ch_rr_i(ch_rr), .grp_rr_i(grp_rr),
    .done_i(done), .gnt_valid_o(gv), .gnt_ch_o(gch),
    .ch_prio_err_o(cerr), .grp_prio_err_o(gerr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor: compares each new grant with the scoreboard head
  always @(negedge clk) begin
    if (gv && !prev_v) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected grant", int'(gch), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(gch) == e, t, int'(gch), e);
      end
    end
    prev_v = gv;
  end

  task automatic set_req(input int a, input int b, input int c, input int d);
    req = '0;
    if (a >= 0) req[a] = 1'b1;
    if (b >= 0) req[b] = 1'b1;
    if (c >= 0) req[c] = 1'b1;
    if (d >= 0) req[d] = 1'b1;
  endtask

  task automatic release_gnt();
    done = 1'b1;
    @(posedge clk); @(negedge clk);
    done = 1'b0;
    chk(gv == 1'b0, "R7 release", int'(gv), 0);
  endtask

  task automatic issue(input int ch, input string t);
    exp_q.push_back(ch);
    tag_q.push_back(t);
    @(posedge clk); @(negedge clk);
    release_gnt();
  endtask

  task automatic wait2();
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; en = '1; ch_rr = 1'b0; grp_rr = 1'b0; done = 1'b0;
    for (int c = 0; c < NCH; c++) chp[c] = 4'(c % 16);
    for (int g = 0; g < NG; g++)  gp[g]  = 2'(g);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gv == 1'b0,   "R1 gnt_valid", int'(gv), 0);
    chk(cerr == 1'b0, "R1 ch_err", int'(cerr), 0);
    chk(gerr == 1'b0, "R1 grp_err", int'(gerr), 0);

    // R4 and R11: round-robin inside bank 0
    ch_rr = 1'b1;
    set_req(2, 5, 9, -1);
    issue(2, "R11 first rr");
    issue(5, "R4 rr step");
    issue(9, "R4 rr step");
    issue(2, "R4 rr wrap");

    // R3: fixed channel priority
    ch_rr = 1'b0;
    issue(9, "R3 fixed max");
    chp[2] = 4'd15; chp[15] = 4'd2;
    issue(2, "R3 fixed reprogram");
    chp[2] = 4'd2; chp[15] = 4'd15;

    // R2: disabled channel ignored
    set_req(5, 9, -1, -1);
    en[9] = 1'b0;
    issue(5, "R2 masked");
    en = '1;

    // R5: fixed bank priority
    set_req(3, 20, 40, -1);
    issue(40, "R5 bank fixed");
    gp[0] = 2'd3; gp[3] = 2'd0;
    issue(3, "R5 bank reprogram");
    gp[0] = 2'd0; gp[3] = 2'd3;

    // R6: bank round-robin, previous winner bank 0
    grp_rr = 1'b1;
    set_req(3, 20, 40, 60);
    issue(20, "R6 bank rr");
    issue(40, "R6 bank rr");
    issue(60, "R6 bank rr");
    issue(3,  "R6 bank rr wrap");
    grp_rr = 1'b0;

    // R7: grant held while request moves
    set_req(3, -1, -1, -1);
    exp_q.push_back(3); tag_q.push_back("R7 first");
    @(posedge clk); @(negedge clk);
    set_req(20, -1, -1, -1);
    exp_q.push_back(20); tag_q.push_back("R7 regrant");
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(gv == 1'b1 && gch == 6'd3, "R7 hold", int'(gch), 3);
    end
    release_gnt();
    @(posedge clk); @(negedge clk);
    chk(gv == 1'b1, "R7 next decision", int'(gv), 1);
    release_gnt();

    // R8: duplicate channel priority blocks grants
    set_req(5, -1, -1, -1);
    chp[7] = 4'd5;
    wait2();
    chk(cerr == 1'b1, "R8 flag", int'(cerr), 1);
    chk(gerr == 1'b0, "R8 other flag", int'(gerr), 0);
    chk(gv == 1'b0, "R8 blocked", int'(gv), 0);
    en[7] = 1'b0;
    exp_q.push_back(5); tag_q.push_back("R8 cleared");
    @(posedge clk); @(negedge clk);
    chk(cerr == 1'b0, "R8 flag clear", int'(cerr), 0);
    release_gnt();
    chp[7] = 4'd7; en = '1;

    // R9: duplicate bank priority blocks grants
    set_req(20, -1, -1, -1);
    gp[1] = 2'd0;
    wait2();
    chk(gerr == 1'b1, "R9 flag", int'(gerr), 1);
    chk(gv == 1'b0, "R9 blocked", int'(gv), 0);
    gp[1] = 2'd1;
    issue(20, "R9 cleared");

    // R10 and R2: nothing active
    req = '0;
    wait2();
    chk(gv == 1'b0, "R10 idle", int'(gv), 0);
    set_req(5, -1, -1, -1);
    en = '0;
    wait2();
    chk(gv == 1'b0, "R2 all masked", int'(gv), 0);
    en = '1; req = '0;
    @(negedge clk);

    chk(exp_q.size() == 0, "R7 pending grants", exp_q.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule